// File: doc/BRIEF.md
# Oscillator Cycle Trim Unit

This block divides a 32.768 kHz oscillator down to a once-per-second enable and corrects for the oscillator's frequency error. The correction adds or removes a programmed number of oscillator counts once per adjustment interval. The interval is either 10 or 60 seconds.

The system clock runs the block. The oscillator arrives as a one-cycle enable, `osc_tick`, that is high once per oscillator period. A prescaler advances on each such enable. A trim byte holds the correction:

- Bits 5:0 hold the magnitude, from 0 to 63 counts.
- Bits 7:6 hold the direction code.

A control write sets two things:

- the automatic-trim enable;
- the interval select.

A change to the interval select is refused while a trim direction is programmed. Software must therefore clear the direction before it moves the interval.

A rate code selects whether the fine periodic tick is produced. The tick comes from the low prescaler bits and occurs 64 times per second at default widths. A sticky flag records each tick.

The block has no data stream, so every pin is plain control or status and there is no valid/ready handshake. The calendar and alarm logic that consume `sec_en` sit outside this block.

Top module: `clk_trim_unit`

## Requirements
- R1: After reset, the following are all 0: `adj_q`, `auto_en_q`, `ten_sec_q`, `rate_q`, `sec_en`, `tick64` and `per_flag`. The second counter starts at zero.
- R2: A write on `adj_wr` stores the whole byte, and `adj_q` returns it from the next cycle. Bits 5:0 are the count N. Bits 7:6 are the mode: 0 none, 1 add, 2 subtract, 3 none.
- R3: A write on `ctl_wr` always updates `auto_en_q`. It updates `ten_sec_q` only when `adj_q[7:6]` is 0 at that edge; otherwise the interval select keeps its value.
- R4: With no trim applied, `sec_en` is a one-cycle pulse once every 2^PRESC_W oscillator enables. It appears one cycle after the edge on which the prescaler wraps.
- R5: The interval boundary is reached at every SHORT_SECS-th `sec_en` pulse counted from reset when `ten_sec_q` is 1, and at every LONG_SECS-th pulse when it is 0. The second that ends at the boundary has nominal length.
- R6: In mode 1 with automatic trim enabled, the prescaler steps by two on each of the N oscillator enables after a boundary. The two seconds that follow the boundary therefore last 2·2^PRESC_W − N enables in total.
- R7: In mode 2 with automatic trim enabled, the prescaler holds for N oscillator enables after a boundary. The two seconds that follow the boundary therefore last 2·2^PRESC_W + N enables.
- R8: No trim is applied in any of these cases: mode 0, mode 3, `auto_en_q` = 0, or N = 0.
- R9: `tick64` pulses for one cycle when the low TICK_W prescaler bits wrap, but only while `rate_q` equals 8. That gives 2^(PRESC_W−TICK_W) ticks per second, and every `sec_en` pulse coincides with a tick. Any other rate code gives no ticks.
- R10: `per_flag` is set the cycle after a `tick64` pulse and stays set until `flag_clr` is applied. A tick on the same cycle as `flag_clr` wins.
- R11: Without `osc_tick`, the prescaler does not advance and no pulses occur. At half rate, the `sec_en` period doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| adj_wr | input | 1 | Write strobe for the trim byte |
| adj_wdata | input | 8 | Trim byte: mode in 7:6, count in 5:0 |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_auto_en | input | 1 | New automatic-trim enable |
| ctl_ten_sec | input | 1 | New interval select (1 = short, 0 = long) |
| rate_wr | input | 1 | Write strobe for the periodic rate code |
| rate_code | input | 4 | New periodic rate code (8 = fine tick) |
| flag_clr | input | 1 | Clears the sticky periodic flag |
| adj_q | output | 8 | Current trim byte |
| auto_en_q | output | 1 | Current automatic-trim enable |
| ten_sec_q | output | 1 | Current interval select |
| rate_q | output | 4 | Current periodic rate code |
| sec_en | output | 1 | Corrected once-per-second pulse |
| tick64 | output | 1 | Fine periodic tick |
| per_flag | output | 1 | Sticky periodic flag |

## Verification
Register writes are due at the outputs on the cycle after the write edge. `sec_en` and `tick64` are registered and arrive one cycle after the oscillator edge that wraps the prescaler. `per_flag` follows `tick64` by one further cycle.

The bench samples every output on the falling clock edge. It judges the trim by the difference between the cycle indices of pulses, so the fixed one-cycle latency cancels out. It counts `sec_en` pulses from reset so that it knows which pulse is the interval boundary. It measures the two seconds after that boundary because a 63-count correction spills into the following second.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;

  localparam int TRIM_N_W = 6;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_ADD  = 2'd1,
    TRIM_SUB  = 2'd2,
    TRIM_RSV  = 2'd3
  } trim_mode_e;

  localparam logic [3:0] RATE_CODE_FINE = 4'h8;

  function automatic logic trim_is_active(input trim_mode_e m);
    return (m == TRIM_ADD) || (m == TRIM_SUB);
  endfunction

endpackage

// File: rtl/trim_regs.sv
module trim_regs
  import clk_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adj_wr,
  input  logic [7:0] adj_wdata,
  input  logic       ctl_wr,
  input  logic       ctl_auto_en,
  input  logic       ctl_ten_sec,
  input  logic       rate_wr,
  input  logic [3:0] rate_code,
  output logic [7:0] adj_q,
  output logic       auto_q,
  output logic       ten_q,
  output logic [3:0] rate_q
);

  trim_mode_e cur_mode;
  assign cur_mode = trim_mode_e'(adj_q[7:6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q  <= '0;
      auto_q <= 1'b0;
      ten_q  <= 1'b0;
      rate_q <= '0;
    end else begin
      if (adj_wr) adj_q <= adj_wdata;
      if (ctl_wr) begin
        auto_q <= ctl_auto_en;
        if (cur_mode == TRIM_NONE) ten_q <= ctl_ten_sec;
      end
      if (rate_wr) rate_q <= rate_code;
    end
  end

  // R3
  ten_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ten_q) |-> ($past(adj_q[7:6]) == 2'd0 && $past(ctl_wr)));

endmodule

// File: rtl/trim_interval.sv
module trim_interval #(
  parameter int SHORT_SECS = 10,
  parameter int LONG_SECS  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_wrap,
  input  logic ten_sel,
  output logic boundary
);

  localparam int SW = $clog2(LONG_SECS + 1);

  logic [SW-1:0] sec_q;
  logic [SW-1:0] last_sec;

  assign last_sec = ten_sel ? SW'(SHORT_SECS - 1) : SW'(LONG_SECS - 1);
  assign boundary = sec_wrap && (sec_q >= last_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_wrap) begin
      sec_q <= boundary ? '0 : sec_q + 1'b1;
    end
  end

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sec_q) < LONG_SECS);

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import clk_trim_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int TICK_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_tick,
  input  logic                load,
  input  logic                load_sub,
  input  logic [TRIM_N_W-1:0] load_n,
  output logic                full_wrap,
  output logic                sec_pulse,
  output logic                sub_pulse
);

  logic [PRESC_W-1:0]  cnt_q;
  logic [TRIM_N_W-1:0] pend_q;
  logic                pend_sub_q;
  logic [1:0]          step;
  logic [PRESC_W:0]    full_sum;
  logic [TICK_W:0]     low_sum;
  logic                low_wrap;

  always_comb begin
    if (pend_q != '0) step = pend_sub_q ? 2'd0 : 2'd2;
    else              step = 2'd1;
  end

  assign full_sum  = {1'b0, cnt_q} + {{(PRESC_W-1){1'b0}}, step};
  assign low_sum   = {1'b0, cnt_q[TICK_W-1:0]} + {{(TICK_W-1){1'b0}}, step};
  assign full_wrap = osc_tick && full_sum[PRESC_W];
  assign low_wrap  = osc_tick && low_sum[TICK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pend_q     <= '0;
      pend_sub_q <= 1'b0;
      sec_pulse  <= 1'b0;
      sub_pulse  <= 1'b0;
    end else begin
      sec_pulse <= full_wrap;
      sub_pulse <= low_wrap;
      if (osc_tick) begin
        cnt_q <= full_sum[PRESC_W-1:0];
        if (load) begin
          pend_q     <= load_n;
          pend_sub_q <= load_sub;
        end else if (pend_q != '0) begin
          pend_q <= pend_q - 1'b1;
        end
      end
    end
  end

  // R7
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && pend_q != '0 && pend_sub_q) |=> $stable(cnt_q));

  // R9
  sec_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> sub_pulse);

  // R4
  sec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

endmodule

// File: rtl/clk_trim_unit.sv
module clk_trim_unit
  import clk_trim_pkg::*;
#(
  parameter int PRESC_W    = 15,
  parameter int TICK_W     = 9,
  parameter int SHORT_SECS = 10,
  parameter int LONG_SECS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       adj_wr,
  input  logic [7:0] adj_wdata,
  input  logic       ctl_wr,
  input  logic       ctl_auto_en,
  input  logic       ctl_ten_sec,
  input  logic       rate_wr,
  input  logic [3:0] rate_code,
  input  logic       flag_clr,
  output logic [7:0] adj_q,
  output logic       auto_en_q,
  output logic       ten_sec_q,
  output logic [3:0] rate_q,
  output logic       sec_en,
  output logic       tick64,
  output logic       per_flag
);

  trim_mode_e mode;
  logic       full_wrap;
  logic       boundary;
  logic       load;
  logic       sub_pulse;

  trim_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .adj_wr     (adj_wr),
    .adj_wdata  (adj_wdata),
    .ctl_wr     (ctl_wr),
    .ctl_auto_en(ctl_auto_en),
    .ctl_ten_sec(ctl_ten_sec),
    .rate_wr    (rate_wr),
    .rate_code  (rate_code),
    .adj_q      (adj_q),
    .auto_q     (auto_en_q),
    .ten_q      (ten_sec_q),
    .rate_q     (rate_q)
  );

  trim_interval #(
    .SHORT_SECS(SHORT_SECS),
    .LONG_SECS (LONG_SECS)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_wrap(full_wrap),
    .ten_sel (ten_sec_q),
    .boundary(boundary)
  );

  assign mode = trim_mode_e'(adj_q[7:6]);
  assign load = boundary && auto_en_q && trim_is_active(mode);

  trim_prescaler #(
    .PRESC_W(PRESC_W),
    .TICK_W (TICK_W)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .load     (load),
    .load_sub (mode == TRIM_SUB),
    .load_n   (adj_q[TRIM_N_W-1:0]),
    .full_wrap(full_wrap),
    .sec_pulse(sec_en),
    .sub_pulse(sub_pulse)
  );

  assign tick64 = sub_pulse && (rate_q == RATE_CODE_FINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_flag <= 1'b0;
    else        per_flag <= tick64 | (per_flag & ~flag_clr);
  end

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick64 |=> per_flag);

endmodule

// File: tb/sim_clk_trim_unit.sv
module sim_clk_trim_unit;

  localparam int PW = 6;
  localparam int TW = 3;
  localparam int SEC = 1 << PW;
  localparam int NV = 9;
  // fields: [21:20] mode, [19:14] count, [13] short interval, [12] auto, [11:0] two-second length
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 6'd5,  1'b1, 1'b1, 12'd123},
    {2'd2, 6'd5,  1'b1, 1'b1, 12'd133},
    {2'd1, 6'd63, 1'b1, 1'b1, 12'd65},
    {2'd2, 6'd63, 1'b0, 1'b1, 12'd191},
    {2'd1, 6'd20, 1'b0, 1'b1, 12'd108},
    {2'd3, 6'd20, 1'b1, 1'b1, 12'd128},
    {2'd0, 6'd20, 1'b1, 1'b1, 12'd128},
    {2'd1, 6'd20, 1'b1, 1'b0, 12'd128},
    {2'd2, 6'd0,  1'b1, 1'b1, 12'd128}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic adj_wr = 1'b0;
  logic [7:0] adj_wdata = '0;
  logic ctl_wr = 1'b0, ctl_auto_en = 1'b0, ctl_ten_sec = 1'b0;
  logic rate_wr = 1'b0;
  logic [3:0] rate_code = '0;
  logic flag_clr = 1'b0;
  logic [7:0] adj_q;
  logic auto_en_q, ten_sec_q, sec_en, tick64, per_flag;
  logic [3:0] rate_q;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int osc_mode = 0;

  clk_trim_unit #(.PRESC_W(PW), .TICK_W(TW), .SHORT_SECS(10), .LONG_SECS(60)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .adj_wr(adj_wr), .adj_wdata(adj_wdata),
    .ctl_wr(ctl_wr), .ctl_auto_en(ctl_auto_en), .ctl_ten_sec(ctl_ten_sec),
    .rate_wr(rate_wr), .rate_code(rate_code), .flag_clr(flag_clr),
    .adj_q(adj_q), .auto_en_q(auto_en_q), .ten_sec_q(ten_sec_q), .rate_q(rate_q),
    .sec_en(sec_en), .tick64(tick64), .per_flag(per_flag)
  );

  always #10ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    case (osc_mode)
      0:       osc_tick <= 1'b1;
      1:       osc_tick <= 1'b0;
      default: osc_tick <= ~osc_tick;
    endcase
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int om);
    @(negedge clk);
    rst_n = 1'b0;
    osc_mode = om;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_adj(input logic [7:0] d);
    adj_wdata = d; adj_wr = 1'b1;
    @(negedge clk);
    adj_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic a, input logic t);
    ctl_auto_en = a; ctl_ten_sec = t; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_rate(input logic [3:0] c);
    rate_code = c; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic wait_sec(output int at);
    do @(negedge clk); while (!sec_en);
    at = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev, at, cnt;
    // R1 reset state
    do_reset(0);
    chk("R1 adj_q", adj_q, 0);
    chk("R1 ctl", {auto_en_q, ten_sec_q}, 0);
    chk("R1 rate", rate_q, 0);
    chk("R1 pulses", {sec_en, tick64, per_flag}, 0);

    // table walk: R2, R4, R5, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic [5:0] n;
      logic ts, au;
      int k, exp;
      m = VEC[v][21:20]; n = VEC[v][19:14]; ts = VEC[v][13]; au = VEC[v][12];
      exp = int'(VEC[v][11:0]);
      k = ts ? 10 : 60;
      do_reset(0);
      wr_ctl(au, ts);
      wr_adj({m, n});
      chk("R2 adj readback", adj_q, {m, n});
      at = 0;
      for (int p = 1; p <= k; p++) begin
        prev = at;
        wait_sec(at);
        if (p == k) chk("R4 R5 pre-boundary second", at - prev, SEC);
      end
      prev = at;
      wait_sec(at);
      wait_sec(at);
      if (au && n != 0 && m == 2'd1)      chk("R6 add trim", at - prev, exp);
      else if (au && n != 0 && m == 2'd2) chk("R7 sub trim", at - prev, exp);
      else                                chk("R8 no trim", at - prev, exp);
    end

    // R3 interval select lock
    do_reset(0);
    wr_adj(8'h45);
    wr_ctl(1'b1, 1'b1);
    chk("R3 locked by add mode", ten_sec_q, 0);
    chk("R3 auto still written", auto_en_q, 1);
    wr_adj(8'h05);
    wr_ctl(1'b0, 1'b1);
    chk("R3 unlocked write", ten_sec_q, 1);
    wr_adj(8'hC0);
    wr_ctl(1'b0, 1'b0);
    chk("R3 locked by code 3", ten_sec_q, 1);

    // R9 fine tick
    do_reset(0);
    wr_rate(4'h8);
    chk("R9 rate readback", rate_q, 8);
    wait_sec(at);
    chk("R9 tick with second", tick64, 1);
    cnt = 0;
    for (int i = 0; i < SEC; i++) begin
      @(negedge clk);
      if (tick64) cnt++;
    end
    chk("R9 ticks per second", cnt, SEC >> TW);

    // R10 sticky flag, set wins over clear
    chk("R10 flag set", per_flag, 1);
    do @(negedge clk); while (!tick64);
    flag_clr = 1'b1;
    @(negedge clk);
    chk("R10 set wins", per_flag, 1);
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R10 cleared", per_flag, 0);

    // R9 other code gives no tick
    wr_rate(4'h4);
    cnt = 0;
    for (int i = 0; i < 2 * SEC; i++) begin
      @(negedge clk);
      if (tick64) cnt++;
    end
    chk("R9 no tick for code 4", cnt, 0);
    chk("R10 flag stays clear", per_flag, 0);

    // R11 oscillator gating
    do_reset(1);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sec_en) cnt++;
    end
    chk("R11 no osc no pulse", cnt, 0);
    osc_mode = 2;
    wait_sec(prev);
    wait_sec(at);
    chk("R11 half rate period", at - prev, 2 * SEC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule